// File: doc/BRIEF.md
# Fixed-Length Burst Address Sequencer

This block produces the address of every beat of a fixed-length bus burst for a manager that issues single transfers and four-, eight- and sixteen-beat incrementing or wrapping bursts. The caller presents a start address, a burst-type code and a transfer-size code together with a one-cycle `start` strobe. From the next cycle on, the block shows the address of the current beat, its index within the burst and a flag on the final beat. It moves to the next beat on every cycle in which `ready` is high.

Incrementing bursts step linearly by the transfer size. Wrapping bursts keep every beat inside an aligned block whose size is the beat count times the transfer size. All wrapping lengths share one modular-increment path. Its mask is worked out when the burst starts, from the burst type and transfer size. The block checks each request before it starts. A request that is unsupported, misaligned, or that would run an incrementing burst across a 1 KB boundary is refused with a one-cycle error pulse and produces no beats.

Top module: `burst_agen`

## Requirements
- R1: In the cycle after `rst` is high, `busy`, `last` and `err` are 0 and `beat` is 0.
- R2: `burst_type` codes are 0 single (1 beat), 2 wrap-4, 3 incr-4, 4 wrap-8, 5 incr-8, 6 wrap-16, 7 incr-16. An accepted burst presents exactly that many beats before `busy` falls.
- R3: For incrementing types (codes 0, 3, 5, 7), each beat address is the previous one plus 2^`xfer_size` bytes, with no wrap.
- R4: For wrapping types (codes 2, 4, 6), the address bits below log2(beats × 2^`xfer_size`) advance modulo that block size and all higher bits stay fixed. For example, word wrap-8 from 0x08 gives 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x00, 0x04.
- R5: While `busy` is high and `ready` is low, `addr` and `beat` hold their values.
- R6: `last` is high exactly when `busy` is high and `beat` equals the beat count minus one. A beat accepted with `last` high returns the block to idle (`busy` low) in the next cycle.
- R7: `start` is ignored while `busy` is high, and the running burst continues unchanged.
- R8: A `start` while idle is refused when any of these holds: `burst_type` is 1; `xfer_size` exceeds MAX_SIZE (2 by default); `start_addr` is not a multiple of 2^`xfer_size`; or an incrementing burst would reach past the end of its 1 KB region. A refused start raises `err` for exactly one cycle and leaves `busy` low.
- R9: `beat` is 0 on the first beat and rises by one on each accepted beat.
- R10: A legal `start` while idle raises `busy` in the next cycle, with `addr` equal to `start_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while idle |
| start_addr | input | ADDR_W | Byte address of the first beat |
| burst_type | input | 3 | Burst kind code (see R2) |
| xfer_size | input | 3 | log2 of bytes per beat |
| ready | input | 1 | Current beat is accepted this cycle |
| busy | output | 1 | A burst is in progress; addr/beat are valid |
| addr | output | ADDR_W | Address of the current beat |
| beat | output | 4 | Index of the current beat |
| last | output | 1 | Current beat is the final one |
| err | output | 1 | One-cycle pulse for a refused start |

## Verification
The assertions check the cycle-level rules on every cycle: address and index stay fixed through wait states, the index steps by one per accepted beat, a burst begins at index zero at the requested address, idle follows an accepted final beat, and an error never coincides with a running burst. Some properties depend on the whole request: the exact address sequence for each type and size, wrapping inside the aligned block, the legality rules at the 1 KB edge, and the burst being unaffected by a start strobe while busy. Only the bench's scenarios can show these, by comparing every beat with a reference model.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;

    typedef enum logic [2:0] {
        BK_SINGLE = 3'd0,
        BK_UNDEF  = 3'd1,
        BK_WRAP4  = 3'd2,
        BK_INCR4  = 3'd3,
        BK_WRAP8  = 3'd4,
        BK_INCR8  = 3'd5,
        BK_WRAP16 = 3'd6,
        BK_INCR16 = 3'd7
    } burst_kind_e;

    typedef struct packed {
        logic [3:0] last_idx;  // beat count minus one
        logic       wrap;      // modular stepping inside the block
        logic [2:0] size;      // log2 bytes per beat
    } burst_cfg_t;

    function automatic logic [3:0] kind_last_idx(input burst_kind_e k);
        case (k)
            BK_WRAP4, BK_INCR4:   return 4'd3;
            BK_WRAP8, BK_INCR8:   return 4'd7;
            BK_WRAP16, BK_INCR16: return 4'd15;
            default:              return 4'd0;
        endcase
    endfunction

    function automatic logic kind_wraps(input burst_kind_e k);
        return (k == BK_WRAP4) || (k == BK_WRAP8) || (k == BK_WRAP16);
    endfunction

endpackage

// File: rtl/burst_agen_decode.sv
module burst_agen_decode
    import burst_agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_SIZE   = 2,
    parameter int BOUND_LOG2 = 10
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_kind,
    input  logic [2:0]        req_size,
    output burst_cfg_t        cfg,
    output logic              legal
);
    // span arithmetic wide enough for offset + 16 beats of 128 bytes
    localparam int SPAN_W = BOUND_LOG2 + 12;
    localparam logic [SPAN_W-1:0] REGION = SPAN_W'(1) << BOUND_LOG2;

    burst_kind_e       kind;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] offset;
    logic [ADDR_W-1:0] low_bits;
    logic              size_ok;
    logic              aligned;
    logic              crosses;

    always_comb begin
        kind         = burst_kind_e'(req_kind);
        cfg.last_idx = kind_last_idx(kind);
        cfg.wrap     = kind_wraps(kind);
        cfg.size     = req_size;

        size_ok  = (int'(req_size) <= MAX_SIZE);
        low_bits = (ADDR_W'(1) << req_size) - ADDR_W'(1);
        aligned  = ((req_addr & low_bits) == '0);

        span   = (SPAN_W'(cfg.last_idx) + SPAN_W'(1)) << req_size;
        offset = SPAN_W'(req_addr[BOUND_LOG2-1:0]);
        crosses = !cfg.wrap && ((offset + span) > REGION);

        legal = (kind != BK_UNDEF) && size_ok && aligned && !crosses;
    end

endmodule

// File: rtl/burst_agen_step.sv
module burst_agen_step
    import burst_agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_cfg_t        cfg,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] block;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        step  = ADDR_W'(1) << cfg.size;
        block = (ADDR_W'(cfg.last_idx) + ADDR_W'(1)) << cfg.size;
        // incrementing bursts use a full mask, so one adder serves all types
        mask  = cfg.wrap ? (block - ADDR_W'(1)) : '1;
        sum   = cur_addr + step;
        next_addr = (cur_addr & ~mask) | (sum & mask);
    end

endmodule

// File: rtl/burst_agen_seq.sv
module burst_agen_seq
    import burst_agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              legal,
    input  burst_cfg_t        cfg_in,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              ready,
    input  logic [ADDR_W-1:0] next_addr,
    output burst_cfg_t        cfg_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [3:0]        beat_q,
    output logic              busy_q,
    output logic              err_q,
    output logic              last
);
    assign last = busy_q && (beat_q == cfg_q.last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
            beat_q <= '0;
            cfg_q  <= '0;
        end else begin
            err_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (legal) begin
                        busy_q <= 1'b1;
                        addr_q <= start_addr;
                        beat_q <= '0;
                        cfg_q  <= cfg_in;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else if (ready) begin
                if (last) begin
                    busy_q <= 1'b0;
                    beat_q <= '0;
                end else begin
                    addr_q <= next_addr;
                    beat_q <= beat_q + 4'd1;
                end
            end
        end
    end

endmodule

// File: rtl/burst_agen.sv
module burst_agen
    import burst_agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_SIZE   = 2,
    parameter int BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [2:0]        burst_type,
    input  logic [2:0]        xfer_size,
    input  logic              ready,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic [3:0]        beat,
    output logic              last,
    output logic              err
);
    burst_cfg_t        req_cfg;
    burst_cfg_t        run_cfg;
    logic              req_legal;
    logic [ADDR_W-1:0] nxt;

    burst_agen_decode #(
        .ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE), .BOUND_LOG2(BOUND_LOG2)
    ) u_decode (
        .req_addr(start_addr),
        .req_kind(burst_type),
        .req_size(xfer_size),
        .cfg(req_cfg),
        .legal(req_legal)
    );

    burst_agen_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr(addr),
        .cfg(run_cfg),
        .next_addr(nxt)
    );

    burst_agen_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk),
        .rst(rst),
        .start(start),
        .legal(req_legal),
        .cfg_in(req_cfg),
        .start_addr(start_addr),
        .ready(ready),
        .next_addr(nxt),
        .cfg_q(run_cfg),
        .addr_q(addr),
        .beat_q(beat),
        .busy_q(busy),
        .err_q(err),
        .last(last)
    );

endmodule

// File: rtl/burst_agen_chk.sv
module burst_agen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              ready,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        beat,
    input logic              last,
    input logic              err
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !last && !err && beat == 4'd0));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ready) |=> ($stable(addr) && $stable(beat) && busy));

    // R6
    last_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ready && last) |=> !busy);

    // R6
    last_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        last |-> busy);

    // R9
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ready && !last) |=> (busy && beat == $past(beat) + 4'd1));

    // R10
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (beat == 4'd0 && addr == $past(start_addr)));

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R7
    start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(ready && last)) |=> busy);

endmodule

bind burst_agen burst_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .ready(ready), .busy(busy), .addr(addr), .beat(beat),
    .last(last), .err(err)
);

// File: tb/burst_agen_test.sv
module burst_agen_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] start_addr;
    logic [2:0]    burst_type;
    logic [2:0]    xfer_size;
    logic          ready;
    logic          busy;
    logic [AW-1:0] addr;
    logic [3:0]    beat;
    logic          last;
    logic          err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst_agen uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .burst_type(burst_type), .xfer_size(xfer_size), .ready(ready),
        .busy(busy), .addr(addr), .beat(beat), .last(last), .err(err)
    );

    function automatic int beats_of(input int code);
        case (code)
            2, 3:    return 4;
            4, 5:    return 8;
            6, 7:    return 16;
            default: return 1;
        endcase
    endfunction

    function automatic bit wraps(input int code);
        return code == 2 || code == 4 || code == 6;
    endfunction

    function automatic bit is_legal(input bit [31:0] a, input int code, input int sz);
        int bytes;
        if (code == 1 || sz > 2) return 0;
        bytes = 1 << sz;
        if (a % bytes != 0) return 0;
        if (!wraps(code) && (int'(a % 1024) + beats_of(code) * bytes > 1024)) return 0;
        return 1;
    endfunction

    function automatic bit [31:0] ref_next(input bit [31:0] a, input int code, input int sz);
        bit [31:0] blk, base;
        if (!wraps(code)) return a + (1 << sz);
        blk  = beats_of(code) * (1 << sz);
        base = a - (a % blk);
        return base + ((a - base + (1 << sz)) % blk);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // pct_ready: percentage chance that ready is high on a beat
    task automatic run_burst(input bit [31:0] a, input int code, input int sz,
                             input int pct_ready, input bit noise);
        bit [31:0] exp_a;
        int n, i;
        bit ok;
        @(negedge clk);
        start = 1'b1; start_addr = a; burst_type = 3'(code); xfer_size = 3'(sz);
        ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        ok = is_legal(a, code, sz);
        if (!ok) begin
            check(err == 1'b1, "R8", "err on refused start", longint'(err), 1);
            check(busy == 1'b0, "R8", "busy after refused start", longint'(busy), 0);
            @(negedge clk);
            check(err == 1'b0, "R8", "err pulse width", longint'(err), 0);
            return;
        end
        check(busy == 1'b1, "R10", "busy after start", longint'(busy), 1);
        check(err == 1'b0, "R8", "err on legal start", longint'(err), 0);
        n = beats_of(code);
        exp_a = a;
        i = 0;
        while (i < n) begin
            check(busy == 1'b1, "R2", "busy mid burst", longint'(busy), 1);
            check(addr == exp_a, wraps(code) ? "R4" : "R3", "beat address",
                  longint'(addr), longint'(exp_a));
            check(beat == 4'(i), "R9", "beat index", longint'(beat), longint'(i));
            check(last == (i == n - 1), "R6", "last flag", longint'(last),
                  longint'(i == n - 1));
            ready = ($urandom % 100) < pct_ready;
            // R7: stray start strobes with other parameters during the burst
            if (noise) begin
                start = $urandom % 2;
                start_addr = $urandom;
                burst_type = 3'($urandom % 8);
                xfer_size = 3'($urandom % 3);
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (ready) begin
                exp_a = ref_next(exp_a, code, sz);
                i++;
            end else begin
                check(addr == exp_a, "R5", "hold address", longint'(addr), longint'(exp_a));
                check(beat == 4'(i), "R5", "hold beat", longint'(beat), longint'(i));
            end
        end
        ready = 1'b0;
        check(busy == 1'b0, "R6", "idle after last beat", longint'(busy), 0);
        check(last == 1'b0, "R6", "last after burst", longint'(last), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; start = 1'b0; start_addr = '0; burst_type = '0;
        xfer_size = '0; ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy", longint'(busy), 0);
        check(last == 1'b0, "R1", "last", longint'(last), 0);
        check(err == 1'b0, "R1", "err", longint'(err), 0);
        check(beat == 4'd0, "R1", "beat", longint'(beat), 0);
        rst = 1'b0;

        // R4: word wrap-8 from 0x08 wraps 0x1C -> 0x00
        run_burst(32'h0000_1008, 4, 2, 100, 1'b0);
        // R4: wrap-4 and wrap-16 at the top of their blocks
        run_burst(32'h0000_200C, 2, 2, 100, 1'b0);
        run_burst(32'h0000_03FE, 6, 1, 70, 1'b0);
        // R3: incr-16 words ending exactly at the 1 KB edge (legal)
        run_burst(32'h0000_07C0, 7, 2, 100, 1'b0);
        // R8: incr-16 one word later crosses the edge
        run_burst(32'h0000_07C4, 7, 2, 100, 1'b0);
        // R8: undefined-length code, oversized transfer, misaligned start
        run_burst(32'h0000_0100, 1, 2, 100, 1'b0);
        run_burst(32'h0000_0100, 5, 3, 100, 1'b0);
        run_burst(32'h0000_0102, 5, 2, 100, 1'b0);
        // R2: single beat
        run_burst(32'h0000_0044, 0, 2, 100, 1'b0);
        // R5: heavy wait states, R7: start noise while busy
        run_burst(32'h0000_3010, 5, 2, 30, 1'b1);

        for (int k = 0; k < 400; k++) begin
            bit [31:0] a;
            int code, sz;
            code = $urandom % 8;
            sz = (($urandom % 10) == 0) ? 3 : ($urandom % 3);
            a = $urandom;
            if (($urandom % 4) != 0) a = a & ~((32'd1 << sz) - 1);
            if (($urandom % 4) == 0) a = (a & ~32'h3FF) | 32'h3C0 | (a & 32'h3F);
            run_burst(a, code, sz, 40 + ($urandom % 61), ($urandom % 2) == 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule